// File: doc/BRIEF.md
# I2C EEPROM Page-Write Slave

This block models the storage side of a serial EEPROM as it appears behind an I2C target interface. A separate front end has already turned the two-wire signalling into strobes: a frame-start pulse, a frame-end pulse, a byte-valid pulse with the received byte, and a read-request pulse each time the master wants one more byte. The block decodes the device-select byte, takes a 16-bit memory address with the high byte first, and gathers the data bytes that follow into a page buffer.

Writes stay inside one page. Only the in-page part of the pointer advances, so a burst longer than a page wraps back to the start of that page and overwrites what was sent first. The buffered bytes reach the array only when the frame-end strobe arrives. A programming interval then follows, and during it the block answers no device select. Reads use the same pointer. An address-only write followed by a read selection gives a random read. Each read request returns one byte and moves the pointer across the whole array, wrapping at its end.

Top module: `ee_page_slave`

## Requirements
- R1: After reset, `ack_o`, `rd_valid_o` and `busy_o` are low, and no frame is open until a start strobe arrives.
- R2: After a start strobe, a select byte of DEV_SEL (0xA0, bit 0 clear) or DEV_SEL|1 (0xA1) is acknowledged with `ack_o` high in the cycle after the byte. Any other select byte is not acknowledged, and no later byte in that frame is acknowledged.
- R3: After a write select, the next two bytes form the address, high byte first. The pointer becomes that 16-bit value modulo MEM_BYTES, and both address bytes are acknowledged.
- R4: Each data byte of a write frame is acknowledged and stored at the pointer. Only the low log2(PAGE_BYTES) bits of the pointer then advance, so byte PAGE_BYTES+k of a burst lands on the same in-page offset as byte k and replaces it.
- R5: Data bytes change the array only when a stop strobe ends the write frame. A start strobe that comes before a stop throws away the buffered bytes.
- R6: A stop that ends a write frame holding at least one data byte raises `busy_o` in the next cycle, for exactly max(PROG_CYCLES, PAGE_BYTES) cycles. A stop after an address-only write does not raise `busy_o`.
- R7: While `busy_o` is high, a select byte (0xA0 or 0xA1) is not acknowledged, and the rest of that frame is ignored.
- R8: After a read select, each read request makes `rd_valid_o` high in the next cycle, with `rd_data_o` equal to the array byte at the pointer. The pointer then advances by one across the whole array and wraps from MEM_BYTES-1 to 0.
- R9: A read request outside a read frame produces no `rd_valid_o`.
- R10: An address-only write, then a start and a read select, reads from the address that was sent.
- R11: A second write burst to the same start address replaces the bytes stored by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame start (or repeated start) strobe |
| stop_i | input | 1 | Frame end strobe |
| byte_valid_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte |
| read_req_i | input | 1 | Master requests the next read byte |
| ack_o | output | 1 | Acknowledge for the byte of the previous cycle |
| rd_valid_o | output | 1 | rd_data_o carries a read byte |
| rd_data_o | output | 8 | Read byte |
| busy_o | output | 1 | Page programming in progress |

## Verification
The assertions assume the front end raises at most one of start, stop, byte-valid and read-request in any cycle. They also assume every frame opens with a start strobe before its select byte. The counter on the busy window assumes busy is only ever started by a stop, never while it is already running. The bench drives every cycle through one task that sets exactly one strobe, or none. Its frame helpers always begin with a start strobe. It waits out every busy window except the one where it deliberately attempts a select during programming.

// File: rtl/ee_pkg.sv
// Package ee_pkg
// Shared frame-decoder state type for the EEPROM page-write slave.
package ee_pkg;

    // Position of the decoder within a bus frame
    typedef enum logic [2:0] {
        ST_IDLE,   // no frame open
        ST_SEL,    // waiting for the device-select byte
        ST_AHI,    // waiting for the address high byte
        ST_ALO,    // waiting for the address low byte
        ST_WR,     // collecting write data
        ST_RD,     // serving read requests
        ST_SKIP    // frame not addressed to this device
    } ee_state_e;

endpackage

// File: rtl/ee_frame_ctrl.sv
// Module ee_frame_ctrl
// Decodes the strobe stream into frame states, owns the address pointer
// and produces the acknowledge. It assumes at most one of the strobes is
// high per cycle; when several are, the priority is start, stop, byte, read.
// MEM_AW must not exceed 16 and must be larger than PAGE_AW.
module ee_frame_ctrl
    import ee_pkg::*;
#(
    parameter int          MEM_AW  = 12,
    parameter int          PAGE_AW = 7,
    parameter logic [7:0]  DEV_SEL = 8'hA0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               byte_valid_i,
    input  logic [7:0]         byte_i,
    input  logic               read_req_i,
    input  logic               busy_i,
    input  logic               buf_pending_i,
    output logic               ack_o,
    output logic               buf_clr_o,
    output logic               buf_wr_o,
    output logic [PAGE_AW-1:0] buf_off_o,
    output logic [7:0]         buf_data_o,
    output logic               commit_o,
    output logic [MEM_AW-1:0]  commit_base_o,
    output logic               rd_en_o,
    output logic [MEM_AW-1:0]  rd_addr_o
);

    ee_state_e          state;
    logic [MEM_AW-1:0]  ptr;
    logic [7:0]         addr_hi;
    logic [15:0]        addr_full;
    logic [PAGE_AW-1:0] off_inc;
    logic               sel_match;
    logic               byte_ev;
    logic               read_ev;

    // Qualified events after applying the strobe priority
    assign byte_ev   = byte_valid_i && !start_i && !stop_i;
    assign read_ev   = read_req_i && !start_i && !stop_i && !byte_valid_i && (state == ST_RD);
    assign addr_full = {addr_hi, byte_i};
    assign off_inc   = ptr[PAGE_AW-1:0] + PAGE_AW'(1);
    assign sel_match = (byte_i[7:1] == DEV_SEL[7:1]);

    // Requests to the page buffer and the array
    assign buf_clr_o     = start_i;
    assign buf_wr_o      = byte_ev && (state == ST_WR);
    assign buf_off_o     = ptr[PAGE_AW-1:0];
    assign buf_data_o    = byte_i;
    assign commit_o      = stop_i && !start_i && (state == ST_WR) && buf_pending_i;
    assign commit_base_o = {ptr[MEM_AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
    assign rd_en_o       = read_ev;
    assign rd_addr_o     = ptr;

    // Frame state, address pointer and acknowledge register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ptr     <= '0;
            addr_hi <= '0;
            ack_o   <= 1'b0;
        end else begin
            ack_o <= 1'b0;
            if (start_i) begin
                state <= ST_SEL;
            end else if (stop_i) begin
                state <= ST_IDLE;
            end else if (byte_ev) begin
                case (state)
                    ST_SEL: begin
                        if (!busy_i && sel_match) begin
                            ack_o <= 1'b1;
                            state <= byte_i[0] ? ST_RD : ST_AHI;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                    ST_AHI: begin
                        addr_hi <= byte_i;
                        ack_o   <= 1'b1;
                        state   <= ST_ALO;
                    end
                    ST_ALO: begin
                        ptr   <= addr_full[MEM_AW-1:0];
                        ack_o <= 1'b1;
                        state <= ST_WR;
                    end
                    ST_WR: begin
                        ptr   <= {ptr[MEM_AW-1:PAGE_AW], off_inc};
                        ack_o <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (read_ev) begin
                ptr <= ptr + MEM_AW'(1);
            end
        end
    end

endmodule

// File: rtl/ee_page_buf.sv
// Module ee_page_buf
// Holds one page of pending write data with a per-byte valid mask. On
// commit it walks the page one offset per cycle and issues a write for
// every valid byte, and it times the programming interval. It assumes no
// new data arrives while the walk is running; a clear during the walk is
// ignored. BUSY_LEN must be at least 2**PAGE_AW.
module ee_page_buf #(
    parameter int MEM_AW   = 12,
    parameter int PAGE_AW  = 7,
    parameter int BUSY_LEN = 160
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_i,
    input  logic [PAGE_AW-1:0] off_i,
    input  logic [7:0]         data_i,
    input  logic               commit_i,
    input  logic [MEM_AW-1:0]  base_i,
    output logic               pending_o,
    output logic               busy_o,
    output logic               mem_we_o,
    output logic [MEM_AW-1:0]  mem_waddr_o,
    output logic [7:0]         mem_wdata_o
);

    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int CNT_W      = $clog2(BUSY_LEN + 1);

    logic [7:0]            page_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic                  walking;
    logic [PAGE_AW-1:0]    idx;
    logic [MEM_AW-1:0]     base_q;
    logic [CNT_W-1:0]      cnt;

    assign pending_o   = |mask_q;
    assign busy_o      = (cnt != '0);
    assign mem_we_o    = walking && mask_q[idx];
    assign mem_waddr_o = {base_q[MEM_AW-1:PAGE_AW], idx};
    assign mem_wdata_o = page_q[idx];

    // Page data storage, written in place at the in-page offset
    always_ff @(posedge clk) begin
        if (wr_i) begin
            page_q[off_i] <= data_i;
        end
    end

    // Valid mask: set by writes, dropped by a clear or as the walk passes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr_i && !walking) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q[off_i] <= 1'b1;
        end else if (walking) begin
            mask_q[idx] <= 1'b0;
        end
    end

    // Commit walker over every in-page offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walking <= 1'b0;
            idx     <= '0;
            base_q  <= '0;
        end else if (commit_i) begin
            walking <= 1'b1;
            idx     <= '0;
            base_q  <= base_i;
        end else if (walking) begin
            idx <= idx + PAGE_AW'(1);
            if (idx == PAGE_AW'(PAGE_BYTES - 1)) begin
                walking <= 1'b0;
            end
        end
    end

    // Programming interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (commit_i) begin
            cnt <= CNT_W'(BUSY_LEN);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/ee_array.sv
// Module ee_array
// Byte array with one write port and one registered read port. The
// contents start in the erased state (all ones) and have no reset.
module ee_array #(
    parameter int MEM_BYTES = 4096,
    parameter int MEM_AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [MEM_AW-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic              rd_en_i,
    input  logic [MEM_AW-1:0] raddr_i,
    output logic              rd_valid_o,
    output logic [7:0]        rd_data_o
);

    logic [7:0] mem [MEM_BYTES];

    // Erased initial contents
    initial begin
        for (int i = 0; i < MEM_BYTES; i++) begin
            mem[i] = 8'hFF;
        end
    end

    // Array write port
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (rd_en_i) begin
            rd_data_o <= mem[raddr_i];
        end
    end

    // Read valid flag, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
        end
    end

endmodule

// File: rtl/ee_page_slave.sv
// Module ee_page_slave
// Top of the EEPROM page-write slave: frame decoder, page buffer with
// commit timer, and byte array. It assumes a front end that turns bus
// activity into single-cycle start, stop, byte and read-request strobes.
module ee_page_slave #(
    parameter int         MEM_BYTES   = 4096,
    parameter int         PAGE_BYTES  = 128,
    parameter int         PROG_CYCLES = 160,
    parameter logic [7:0] DEV_SEL     = 8'hA0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    input  logic       read_req_i,
    output logic       ack_o,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o,
    output logic       busy_o
);

    localparam int MEM_AW   = $clog2(MEM_BYTES);
    localparam int PAGE_AW  = $clog2(PAGE_BYTES);
    localparam int BUSY_LEN = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES;

    logic               buf_clr;
    logic               buf_wr;
    logic [PAGE_AW-1:0] buf_off;
    logic [7:0]         buf_data;
    logic               commit;
    logic [MEM_AW-1:0]  commit_base;
    logic               rd_en;
    logic [MEM_AW-1:0]  rd_addr;
    logic               pending;
    logic               mem_we;
    logic [MEM_AW-1:0]  mem_waddr;
    logic [7:0]         mem_wdata;

    ee_frame_ctrl #(
        .MEM_AW  (MEM_AW),
        .PAGE_AW (PAGE_AW),
        .DEV_SEL (DEV_SEL)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .stop_i        (stop_i),
        .byte_valid_i  (byte_valid_i),
        .byte_i        (byte_i),
        .read_req_i    (read_req_i),
        .busy_i        (busy_o),
        .buf_pending_i (pending),
        .ack_o         (ack_o),
        .buf_clr_o     (buf_clr),
        .buf_wr_o      (buf_wr),
        .buf_off_o     (buf_off),
        .buf_data_o    (buf_data),
        .commit_o      (commit),
        .commit_base_o (commit_base),
        .rd_en_o       (rd_en),
        .rd_addr_o     (rd_addr)
    );

    ee_page_buf #(
        .MEM_AW   (MEM_AW),
        .PAGE_AW  (PAGE_AW),
        .BUSY_LEN (BUSY_LEN)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (buf_clr),
        .wr_i        (buf_wr),
        .off_i       (buf_off),
        .data_i      (buf_data),
        .commit_i    (commit),
        .base_i      (commit_base),
        .pending_o   (pending),
        .busy_o      (busy_o),
        .mem_we_o    (mem_we),
        .mem_waddr_o (mem_waddr),
        .mem_wdata_o (mem_wdata)
    );

    ee_array #(
        .MEM_BYTES (MEM_BYTES),
        .MEM_AW    (MEM_AW)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (mem_we),
        .waddr_i    (mem_waddr),
        .wdata_i    (mem_wdata),
        .rd_en_i    (rd_en),
        .raddr_i    (rd_addr),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

endmodule

// File: rtl/ee_page_slave_chk.sv
// Module ee_page_slave_chk
// Port-level temporal checks for ee_page_slave, bound to every instance.
// It assumes at most one strobe per cycle and frames that open with start.
module ee_page_slave_chk #(
    parameter int BUSY_LEN = 160
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       stop_i,
    input logic       byte_valid_i,
    input logic [7:0] byte_i,
    input logic       read_req_i,
    input logic       ack_o,
    input logic       rd_valid_o,
    input logic [7:0] rd_data_o,
    input logic       busy_o
);

    logic expect_sel;
    int   busy_len;

    // Tracks whether the next byte is the first of a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_sel <= 1'b0;
        end else if (start_i) begin
            expect_sel <= 1'b1;
        end else if (byte_valid_i || stop_i) begin
            expect_sel <= 1'b0;
        end
    end

    // Counts the length of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= 0;
        end else if (busy_o) begin
            busy_len <= busy_len + 1;
        end else begin
            busy_len <= 0;
        end
    end

    // R2: an acknowledge only ever follows a received byte
    a_r2_ack_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i |=> !ack_o);

    // R9: read data only ever follows a read request
    a_r9_rdvalid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !read_req_i |=> !rd_valid_o);

    // R7: no select is acknowledged during programming
    a_r7_no_sel_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && byte_valid_i && expect_sel) |=> !ack_o);

    // R5: programming begins only on a stop strobe
    a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R6: the programming window has its full length
    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len == BUSY_LEN));

    // R8: no read data appears during programming
    a_r8_no_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !busy_o);

endmodule

bind ee_page_slave ee_page_slave_chk #(.BUSY_LEN(BUSY_LEN)) u_chk (.*);

// File: tb/ee_page_slave_bench.sv
// Bench for ee_page_slave: a behavioural reference model advanced on
// every clock and compared with all outputs at the falling edge.
module ee_page_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 4096;
    localparam int PAGE       = 128;
    localparam int PROG       = 160;
    localparam int BUSY       = (PROG > PAGE) ? PROG : PAGE;

    logic       clk;
    logic       rst_n;
    logic       start_i, stop_i, byte_valid_i, read_req_i;
    logic [7:0] byte_i;
    logic       ack_o, rd_valid_o, busy_o;
    logic [7:0] rd_data_o;

    ee_page_slave #(
        .MEM_BYTES   (MEM_BYTES),
        .PAGE_BYTES  (PAGE),
        .PROG_CYCLES (PROG),
        .DEV_SEL     (8'hA0)
    ) u_ee_page_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .read_req_i   (read_req_i),
        .ack_o        (ack_o),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o),
        .busy_o       (busy_o)
    );

    int    checks = 0;
    int    errors = 0;
    string tag    = "R1";

    // Reference model state: 0 idle, 1 select, 2 addr hi, 3 addr lo, 4 write, 5 read, 6 skip
    int         m_st = 0;
    int         m_ptr = 0;
    int         m_hi = 0;
    int         m_busy = 0;
    logic [7:0] m_mem [MEM_BYTES];
    int         m_buf [int];
    bit         e_ack = 0;
    bit         e_rv = 0;
    logic [7:0] e_rd = 8'h00;

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_update(input bit s, input bit p, input bit bv, input logic [7:0] b, input bit rr);
        bit old_busy;
        int base;
        old_busy = (m_busy != 0);
        e_ack = 0;
        e_rv  = 0;
        if (m_busy > 0) m_busy--;
        if (s) begin
            m_st = 1;
            m_buf.delete();
        end else if (p) begin
            if (m_st == 4 && m_buf.num() > 0) begin
                base = (m_ptr / PAGE) * PAGE;
                foreach (m_buf[k]) m_mem[base + k] = m_buf[k][7:0];
                m_buf.delete();
                m_busy = BUSY;
            end
            m_st = 0;
        end else if (bv) begin
            case (m_st)
                1: begin
                    if (!old_busy && b == 8'hA0) begin m_st = 2; e_ack = 1; end
                    else if (!old_busy && b == 8'hA1) begin m_st = 5; e_ack = 1; end
                    else m_st = 6;
                end
                2: begin m_hi = b; e_ack = 1; m_st = 3; end
                3: begin m_ptr = ((m_hi << 8) | b) % MEM_BYTES; m_buf.delete(); e_ack = 1; m_st = 4; end
                4: begin
                    m_buf[m_ptr % PAGE] = b;
                    m_ptr = (m_ptr / PAGE) * PAGE + ((m_ptr % PAGE) + 1) % PAGE;
                    e_ack = 1;
                end
                default: ;
            endcase
        end else if (rr && m_st == 5) begin
            e_rv  = 1;
            e_rd  = m_mem[m_ptr];
            m_ptr = (m_ptr + 1) % MEM_BYTES;
        end
    endtask

    task automatic step(input bit s, input bit p, input bit bv, input logic [7:0] b, input bit rr);
        start_i = s; stop_i = p; byte_valid_i = bv; byte_i = b; read_req_i = rr;
        @(posedge clk);
        model_update(s, p, bv, b, rr);
        @(negedge clk);
        check(ack_o == e_ack, "ack_o", ack_o, e_ack);
        check(rd_valid_o == e_rv, "rd_valid_o", rd_valid_o, e_rv);
        if (e_rv) check(rd_data_o == e_rd, "rd_data_o", rd_data_o, e_rd);
        check(busy_o == (m_busy != 0), "busy_o", busy_o, (m_busy != 0));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0);
    endtask

    task automatic wait_ready();
        while (m_busy != 0) idle(1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        step(0, 0, 1, b, 0);
    endtask

    task automatic open_write(input int addr);
        step(1, 0, 0, 8'h00, 0);
        send_byte(8'hA0);
        send_byte(addr[15:8]);
        send_byte(addr[7:0]);
    endtask

    task automatic write_burst(input int addr, input int n, input int seed);
        open_write(addr);
        for (int i = 0; i < n; i++) send_byte(8'((seed + i * 7) & 8'hFF));
        step(0, 1, 0, 8'h00, 0);
    endtask

    task automatic read_burst(input int addr, input int n);
        open_write(addr);
        step(1, 0, 0, 8'h00, 0);
        send_byte(8'hA1);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 1);
        step(0, 1, 0, 8'h00, 0);
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) m_mem[i] = 8'hFF;
        rst_n = 1'b0;
        start_i = 0; stop_i = 0; byte_valid_i = 0; byte_i = 0; read_req_i = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet after reset
        tag = "R1";
        check(ack_o == 1'b0, "ack_o after reset", ack_o, 0);
        check(rd_valid_o == 1'b0, "rd_valid_o after reset", rd_valid_o, 0);
        check(busy_o == 1'b0, "busy_o after reset", busy_o, 0);
        rst_n = 1'b1;
        idle(2);
        send_byte(8'hA0);                 // R1: no frame open, no ack

        tag = "R2";                       // wrong select, then ignored bytes
        step(1, 0, 0, 8'h00, 0);
        send_byte(8'h50);
        send_byte(8'h00);
        send_byte(8'h12);
        step(0, 1, 0, 8'h00, 0);
        check(busy_o == 1'b0, "no busy after foreign frame", busy_o, 0);

        tag = "R9";                       // read requests outside a read frame
        idle(1);
        step(0, 0, 0, 8'h00, 1);
        open_write(16'h0040);
        step(0, 0, 0, 8'h00, 1);
        step(0, 1, 0, 8'h00, 0);

        tag = "R6";                       // address-only write: no busy
        check(busy_o == 1'b0, "address-only write busy", busy_o, 0);

        tag = "R4";                       // short write, programming window
        write_burst(16'h0105, 3, 8'h31);
        tag = "R6";
        wait_ready();
        tag = "R10";                      // random read of it
        read_burst(16'h0104, 5);

        tag = "R7";                       // selection during programming
        write_burst(16'h0278, 12, 8'h80); // R4: wraps inside page 0x200
        step(1, 0, 0, 8'h00, 0);
        send_byte(8'hA0);
        send_byte(8'h02);
        send_byte(8'h00);
        step(0, 1, 0, 8'h00, 0);
        step(1, 0, 0, 8'h00, 0);
        send_byte(8'hA1);
        step(0, 0, 0, 8'h00, 1);
        step(0, 1, 0, 8'h00, 0);
        wait_ready();
        tag = "R4";
        read_burst(16'h0200, 6);
        read_burst(16'h0276, 12);

        tag = "R5";                       // repeated start discards buffer
        open_write(16'h0500);
        send_byte(8'h11);
        send_byte(8'h22);
        step(1, 0, 0, 8'h00, 0);
        step(0, 1, 0, 8'h00, 0);
        check(busy_o == 1'b0, "discarded frame busy", busy_o, 0);
        read_burst(16'h0500, 3);

        tag = "R11";                      // rewrite same start address
        write_burst(16'h0600, 4, 8'h10);
        wait_ready();
        write_burst(16'h0600, 4, 8'hC0);
        wait_ready();
        read_burst(16'h0600, 5);

        tag = "R4";                       // burst longer than a page
        write_burst(16'h0300, PAGE + 2, 8'h05);
        wait_ready();
        read_burst(16'h0300, 4);
        read_burst(16'h037E, 3);

        tag = "R3";                       // address above the array folds down
        write_burst(16'h1FFE, 4, 8'hE0);
        wait_ready();
        tag = "R8";                       // read wraps at end of array
        read_burst(16'h0FFE, 5);
        read_burst(16'h0F80, 3);

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog %s: actual timeout expected completion", tag);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule